// File: doc/BRIEF.md
# SPI Master with Transmit/Receive FIFOs and Single-Shot FIFO Clear

This block is a serial-peripheral master that moves fixed-width data units between two small FIFOs and the four serial lines (serial clock, master-out, master-in, active-low select). Software writes a control byte that holds a clock-run enable, a transmit enable, a receive enable, a continuous-receive mode bit, a self-clearing FIFO-clear bit and a 3-bit divider select. It pushes units into the transmit FIFO and pops captured units from the receive FIFO.

A unit starts when the clock is running and one of two conditions holds. Either transmission is enabled and the transmit FIFO holds data, or continuous receive is enabled. In the second case the master sends all-ones filler units. The enables are sampled only when a unit starts, so clearing one lets the unit already in flight finish. The FIFO-clear bit empties both FIFOs and leaves every configuration field as it was. Continuous receive therefore keeps going across a clear, and it stops only when receive is disabled. Each received unit raises a one-cycle receive-end pulse.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset the control readback is 0, `sclk` is 0, `cs_n` is 1, both FIFOs are empty and the overrun flag is 0. The FIFO-clear bit (write bit 4) always reads back as 0 and never needs a 0 written to it.
- R2: Each unit is 8 bits, sent and received MSB first, in mode 0. `mosi` changes after a falling `sclk` edge and `miso` is captured at each rising `sclk` edge. `cs_n` is low for exactly the unit. A transmitted byte appears on `mosi`, and the byte on `miso` lands in the receive FIFO when receive is enabled (write bit 2).
- R3: Write bits 7:5 select the bit-clock period in system cycles: 0→2, 1→3, 2→4, 3→8, 4→16, 5→64, 6→256, 7→256. `sclk` is high for floor(period/2) cycles of each bit, and a unit keeps `cs_n` low for 8×period cycles.
- R4: With the clock-run bit (write bit 0) at 0, no unit starts, `sclk` stays low and queued transmit data is kept. Setting the bit later sends that data.
- R5: Clearing transmit enable (write bit 1) while a unit is in flight lets that unit complete all 8 bits. No further unit starts, even though the transmit FIFO still holds data.
- R6: Writing 1 to the FIFO-clear bit empties both FIFOs and clears the overrun flag. Discarded transmit data is never sent, even after transmission is enabled again.
- R7: A single control write that sets both the clock-run bit and the FIFO-clear bit applies both. A FIFO clear leaves the other control fields unchanged in the readback.
- R8: `rend_irq` pulses for exactly one cycle per unit received with receive enabled, and never otherwise.
- R9: With receive enable and continuous mode (write bit 3) set and transmit disabled, units repeat back to back with `mosi` all ones. They continue across a FIFO clear and stop after the current unit once receive enable is cleared.
- R10: The transmit FIFO holds 4 units. `tx_full` is set when it holds 4, and a push while it is full is dropped.
- R11: A unit that completes while the receive FIFO is full is discarded and sets the sticky `rx_overrun`. The FIFO contents are unchanged, and only a FIFO clear resets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control write data {sel[2:0], clear, cont, rx_en, tx_en, run} |
| cfg_rdata | output | 8 | Control readback, clear bit reads 0 |
| tx_we | input | 1 | Push strobe for transmit FIFO |
| tx_wdata | input | UNIT_W | Unit to push |
| tx_full | output | 1 | Transmit FIFO full |
| tx_empty | output | 1 | Transmit FIFO empty |
| rx_re | input | 1 | Pop strobe for receive FIFO |
| rx_rdata | output | UNIT_W | Head of receive FIFO |
| rx_full | output | 1 | Receive FIFO full |
| rx_empty | output | 1 | Receive FIFO empty |
| rx_overrun | output | 1 | Sticky receive overrun |
| rend_irq | output | 1 | One-cycle receive-end pulse |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low select, low during a unit |

## Verification
A corrupted FIFO pointer shows up within one unit. The peripheral model sees the wrong or a stale byte on `mosi`, or a popped receive byte differs from the pattern driven on `miso`. A wrong divider or phase counter changes the measured high time and the select-low width of the very first unit. A lost enable sample or a broken clear shows as an extra or missing select-low window, which is counted against the expected number of units within a few hundred cycles. A bad receive flag shows as a mismatch between pulse count and unit count over the continuous-receive phase.

// File: rtl/spim_pkg.sv
package spim_pkg;

  localparam int DIV_W = 9;

  typedef struct packed {
    logic [2:0] sel;
    logic       cont;
    logic       rx_en;
    logic       tx_en;
    logic       run;
  } spim_cfg_t;

  function automatic logic [DIV_W-1:0] period_of(input logic [2:0] sel);
    logic [DIV_W-1:0] p;
    case (sel)
      3'd0:    p = 9'd2;
      3'd1:    p = 9'd3;
      3'd2:    p = 9'd4;
      3'd3:    p = 9'd8;
      3'd4:    p = 9'd16;
      3'd5:    p = 9'd64;
      default: p = 9'd256;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [AW-1:0]      wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0]      cnt_q, cnt_d;
  logic [DEPTH*W-1:0] flat;
  logic               push_ok, pop_ok;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push && !full && !clr;
  assign pop_ok  = pop && !empty && !clr;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (clr) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (push_ok) wr_d = (wr_q == AW'(DEPTH-1)) ? '0 : wr_q + 1'b1;
      if (pop_ok)  rd_d = (rd_q == AW'(DEPTH-1)) ? '0 : rd_q + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [W-1:0] ent_q;
    logic         ent_we;
    assign ent_we = push_ok && (wr_q == AW'(i));
    always_ff @(posedge clk) begin
      if (ent_we) ent_q <= din;
    end
    assign flat[i*W +: W] = ent_q;
  end

  assign dout = flat[rd_q*W +: W];

  p_clr_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> empty) else $error("fifo not empty after clear");
  p_flags_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty)) else $error("fifo full and empty");
  p_full_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    full && push && !pop && !clr |=> full) else $error("push on full changed level");

endmodule

// File: rtl/spim_clkdiv.sv
module spim_clkdiv
  import spim_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [2:0] sel,
  output logic       rise_tick,
  output logic       fall_tick
);
  logic [DIV_W-1:0] per, low_len, cnt_q, cnt_d;

  assign per     = period_of(sel);
  assign low_len = (per + 9'd1) >> 1;

  always_comb begin
    if (!run)                  cnt_d = '0;
    else if (cnt_q == per - 1) cnt_d = '0;
    else                       cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign rise_tick = run && (cnt_q == low_len - 1);
  assign fall_tick = run && (cnt_q == per - 1);

  p_phase_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> cnt_q == '0) else $error("bit phase not aligned at unit start");

endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
  parameter int UNIT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [UNIT_W-1:0] tx_word,
  input  logic              rise_tick,
  input  logic              fall_tick,
  input  logic              miso,
  output logic              busy,
  output logic              sclk,
  output logic              mosi,
  output logic              done,
  output logic [UNIT_W-1:0] rx_word
);
  localparam int BW = $clog2(UNIT_W);

  logic              busy_q, busy_d, sclk_q, sclk_d, done_q, done_d;
  logic [UNIT_W-1:0] sh_q, sh_d, rx_q, rx_d;
  logic [BW-1:0]     bit_q, bit_d;
  logic              last_bit;

  assign last_bit = (bit_q == BW'(UNIT_W-1));

  always_comb begin
    busy_d = busy_q;
    sclk_d = sclk_q;
    sh_d   = sh_q;
    rx_d   = rx_q;
    bit_d  = bit_q;
    done_d = 1'b0;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        sh_d   = tx_word;
        bit_d  = '0;
        sclk_d = 1'b0;
      end
    end else begin
      if (rise_tick) begin
        sclk_d = 1'b1;
        rx_d   = {rx_q[UNIT_W-2:0], miso};
      end
      if (fall_tick) begin
        sclk_d = 1'b0;
        if (last_bit) begin
          busy_d = 1'b0;
          done_d = 1'b1;
        end else begin
          bit_d = bit_q + 1'b1;
          sh_d  = {sh_q[UNIT_W-2:0], 1'b1};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      done_q <= 1'b0;
      sh_q   <= '1;
      rx_q   <= '0;
      bit_q  <= '0;
    end else begin
      busy_q <= busy_d;
      sclk_q <= sclk_d;
      done_q <= done_d;
      sh_q   <= sh_d;
      rx_q   <= rx_d;
      bit_q  <= bit_d;
    end
  end

  assign busy    = busy_q;
  assign sclk    = sclk_q;
  assign mosi    = busy_q ? sh_q[UNIT_W-1] : 1'b1;
  assign done    = done_q;
  assign rx_word = rx_q;

  p_sclk_in_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !sclk_q) else $error("sclk high outside a unit");
  p_done_ends_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $fell(busy_q)) else $error("done without unit end");

endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
  import spim_pkg::*;
#(
  parameter int UNIT_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              tx_we,
  input  logic [UNIT_W-1:0] tx_wdata,
  output logic              tx_full,
  output logic              tx_empty,
  input  logic              rx_re,
  output logic [UNIT_W-1:0] rx_rdata,
  output logic              rx_full,
  output logic              rx_empty,
  output logic              rx_overrun,
  output logic              rend_irq,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              cs_n
);
  spim_cfg_t         cfg_q, cfg_d;
  logic              clr_q, clr_d, cap_q, cap_d, ovr_q, ovr_d;
  logic              busy, done, rise_tick, fall_tick;
  logic              tx_go, cont_go, start, rx_push;
  logic [UNIT_W-1:0] tx_head, tx_word, rx_word;

  // control register: configuration persists, clear bit is a one-cycle pulse
  always_comb begin
    cfg_d = cfg_q;
    clr_d = 1'b0;
    if (cfg_we) begin
      cfg_d = '{sel: cfg_wdata[7:5], cont: cfg_wdata[3], rx_en: cfg_wdata[2],
                tx_en: cfg_wdata[1], run: cfg_wdata[0]};
      clr_d = cfg_wdata[4];
    end
  end

  // unit start: enables sampled only here; no start while a clear is pending
  assign tx_go   = cfg_q.tx_en && !tx_empty;
  assign cont_go = cfg_q.rx_en && cfg_q.cont;
  assign start   = cfg_q.run && !busy && !clr_q && (tx_go || cont_go);
  assign tx_word = tx_go ? tx_head : '1;
  assign cap_d   = (start && !busy) ? cfg_q.rx_en : cap_q;
  assign rx_push = done && cap_q;

  always_comb begin
    ovr_d = ovr_q;
    if (clr_q)                  ovr_d = 1'b0;
    else if (rx_push && rx_full) ovr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      clr_q <= 1'b0;
      cap_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      clr_q <= clr_d;
      cap_q <= cap_d;
      ovr_q <= ovr_d;
    end
  end

  spim_fifo #(.W(UNIT_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(clr_q),
    .push(tx_we), .din(tx_wdata),
    .pop(start && tx_go), .dout(tx_head),
    .full(tx_full), .empty(tx_empty)
  );

  spim_fifo #(.W(UNIT_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(clr_q),
    .push(rx_push), .din(rx_word),
    .pop(rx_re), .dout(rx_rdata),
    .full(rx_full), .empty(rx_empty)
  );

  spim_clkdiv u_div (
    .clk(clk), .rst_n(rst_n), .run(busy && cfg_q.run), .sel(cfg_q.sel),
    .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  spim_shifter #(.UNIT_W(UNIT_W)) u_shf (
    .clk(clk), .rst_n(rst_n), .start(start), .tx_word(tx_word),
    .rise_tick(rise_tick), .fall_tick(fall_tick), .miso(miso),
    .busy(busy), .sclk(sclk), .mosi(mosi), .done(done), .rx_word(rx_word)
  );

  assign cfg_rdata  = {cfg_q.sel, 1'b0, cfg_q.cont, cfg_q.rx_en, cfg_q.tx_en, cfg_q.run};
  assign rx_overrun = ovr_q;
  assign rend_irq   = rx_push;
  assign cs_n       = !busy;

  p_clr_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q && !cfg_we |=> !clr_q) else $error("clear pulse not self-clearing");
  p_off_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q.run && cs_n |=> cs_n) else $error("unit started with clock stopped");
  p_irq_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rend_irq |=> !rend_irq) else $error("receive-end longer than one cycle");
  p_ovr_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun && !clr_q |=> rx_overrun) else $error("overrun dropped without clear");

endmodule

// File: tb/test_spi_fifo_master.sv
`timescale 1ns/1ps
module test_spi_fifo_master;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0, tx_we = 1'b0, rx_re = 1'b0;
  logic [7:0] cfg_wdata = '0, tx_wdata = '0;
  logic [7:0] cfg_rdata, rx_rdata;
  logic       tx_full, tx_empty, rx_full, rx_empty, rx_overrun, rend_irq;
  logic       sclk, mosi, miso, cs_n;

  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  spi_fifo_master i_spi_fifo_master (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .tx_we(tx_we), .tx_wdata(tx_wdata), .tx_full(tx_full), .tx_empty(tx_empty),
    .rx_re(rx_re), .rx_rdata(rx_rdata), .rx_full(rx_full), .rx_empty(rx_empty),
    .rx_overrun(rx_overrun), .rend_irq(rend_irq),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  // peripheral model
  logic [7:0] slv_pat = 8'h00;
  logic [7:0] slv_rx = 8'h00;
  logic [2:0] sidx = 3'd0;
  logic [7:0] mlog [0:15];
  int n_units = 0, n_rises = 0, n_irq = 0;

  assign miso = cs_n ? 1'b0 : slv_pat[3'd7 - sidx];
  always @(negedge sclk or posedge cs_n) begin
    if (cs_n) sidx <= 3'd0;
    else      sidx <= sidx + 3'd1;
  end
  always @(posedge sclk) begin
    slv_rx  <= {slv_rx[6:0], mosi};
    n_rises <= n_rises + 1;
  end
  always @(posedge cs_n) begin
    mlog[n_units[3:0]] = slv_rx;
    n_units = n_units + 1;
  end
  always @(negedge clk) if (rend_irq === 1'b1) n_irq <= n_irq + 1;

  function automatic int exp_period(input int sel);
    case (sel)
      0: return 2;  1: return 3;  2: return 4;  3: return 8;
      4: return 16; 5: return 64; default: return 256;
    endcase
  endfunction

  function automatic logic [7:0] cfgv(input bit run, input bit tx, input bit rx,
                                      input bit cont, input bit clr, input int sel);
    return {sel[2:0], clr, cont, rx, tx, run};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [7:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk); tx_we = 1'b1; tx_wdata = b;
    @(negedge clk); tx_we = 1'b0;
  endtask

  task automatic pop(output logic [7:0] b);
    @(negedge clk); b = rx_rdata; rx_re = 1'b1;
    @(negedge clk); rx_re = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_units(input int base, input int n, input int lim);
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (n_units - base >= n) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] b, d0;
    int u0, r0, i0, hi, tot;
    void'($urandom(32'd4242));
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    chk(cfg_rdata == 8'h00, "R1 cfg", cfg_rdata, 0);
    chk(sclk == 1'b0 && cs_n == 1'b1, "R1 lines", {sclk, cs_n}, 1);
    chk(tx_empty && rx_empty && !rx_overrun, "R1 flags", {tx_empty, rx_empty, rx_overrun}, 6);

    // R7 run + clear in one write; data queued while stopped is discarded
    push(8'h5A); push(8'hA5);
    chk(!tx_empty, "R4 queued", tx_empty, 0);
    wr_cfg(cfgv(1, 0, 0, 0, 1, 0));
    idle(2);
    chk(tx_empty, "R7 clear applied", tx_empty, 1);
    chk(cfg_rdata == 8'h01, "R7 run applied, R1 clear reads 0", cfg_rdata, 8'h01);
    u0 = n_units;
    wr_cfg(cfgv(1, 1, 0, 0, 0, 0));
    idle(60);
    chk(n_units == u0, "R6 discarded never sent", n_units - u0, 0);

    // R2 R3 R8 full-duplex units at every divider setting
    for (int sel = 0; sel < 8; sel++) begin
      d0 = 8'($urandom);
      slv_pat = 8'($urandom);
      wr_cfg(cfgv(1, 1, 1, 0, 0, sel));
      u0 = n_units; i0 = n_irq;
      push(d0);
      hi = 0; tot = 0;
      for (int k = 0; k < 5000 && cs_n; k++) @(negedge clk);
      while (!cs_n && tot < 5000) begin
        tot++;
        if (sclk) hi++;
        @(negedge clk);
      end
      idle(2);
      chk(tot == 8 * exp_period(sel), "R3 unit length", tot, 8 * exp_period(sel));
      chk(hi == 8 * (exp_period(sel) / 2), "R3 high time", hi, 8 * (exp_period(sel) / 2));
      chk(mlog[u0[3:0]] == d0, "R2 mosi byte", mlog[u0[3:0]], d0);
      chk(n_irq - i0 == 1, "R8 one pulse", n_irq - i0, 1);
      pop(b);
      chk(b == slv_pat, "R2 miso byte", b, slv_pat);
    end

    // R4 stopped clock holds data, then sends it
    wr_cfg(cfgv(0, 1, 0, 0, 0, 0));
    u0 = n_units; r0 = n_rises;
    push(8'h3C);
    idle(50);
    chk(n_units == u0 && n_rises == r0 && !tx_empty, "R4 no activity", n_rises - r0, 0);
    wr_cfg(cfgv(1, 1, 0, 0, 0, 0));
    wait_units(u0, 1, 500);
    chk(mlog[u0[3:0]] == 8'h3C, "R4 sent after run", mlog[u0[3:0]], 8'h3C);

    // R10 R11 transmit full, receive overrun
    wr_cfg(cfgv(0, 1, 1, 0, 0, 0));
    slv_pat = 8'h96;
    push(8'h11); push(8'h22); push(8'h33); push(8'h44);
    chk(tx_full, "R10 full at 4", tx_full, 1);
    push(8'h55);
    u0 = n_units;
    wr_cfg(cfgv(1, 1, 1, 0, 0, 0));
    wait_units(u0, 4, 1000);
    idle(40);
    chk(n_units - u0 == 4, "R10 extra dropped", n_units - u0, 4);
    chk(mlog[u0[3:0]] == 8'h11 && mlog[4'(u0 + 3)] == 8'h44, "R10 order", mlog[4'(u0 + 3)], 8'h44);
    chk(rx_full && !rx_overrun, "R11 full no overrun", {rx_full, rx_overrun}, 2);
    slv_pat = 8'h69;
    push(8'h66);
    wait_units(u0, 5, 500);
    idle(3);
    chk(rx_overrun, "R11 overrun set", rx_overrun, 1);
    for (int k = 0; k < 4; k++) begin
      pop(b);
      chk(b == 8'h96, "R11 contents kept", b, 8'h96);
    end
    chk(rx_empty && rx_overrun, "R11 sticky", {rx_empty, rx_overrun}, 3);

    // R5 transmit disable mid unit
    wr_cfg(cfgv(0, 1, 0, 0, 0, 2));
    push(8'hE1); push(8'hE2); push(8'hE3);
    u0 = n_units; r0 = n_rises;
    wr_cfg(cfgv(1, 1, 0, 0, 0, 2));
    for (int k = 0; k < 100 && cs_n; k++) @(negedge clk);
    idle(5);
    wr_cfg(cfgv(1, 0, 0, 0, 0, 2));
    idle(150);
    chk(n_units - u0 == 1, "R5 one unit", n_units - u0, 1);
    chk(n_rises - r0 == 8, "R5 unit completed", n_rises - r0, 8);
    chk(!tx_empty, "R5 data left", tx_empty, 0);

    // R6 clear discards data, clears overrun, keeps config (R7)
    wr_cfg(cfgv(1, 0, 0, 0, 1, 2));
    idle(2);
    chk(tx_empty && rx_empty && !rx_overrun, "R6 cleared", {tx_empty, rx_empty, rx_overrun}, 6);
    chk(cfg_rdata == 8'h41, "R7 config kept", cfg_rdata, 8'h41);
    u0 = n_units;
    wr_cfg(cfgv(1, 1, 0, 0, 0, 2));
    idle(100);
    chk(n_units == u0, "R6 no resend", n_units - u0, 0);
    push(8'hC3);
    wait_units(u0, 1, 500);
    chk(mlog[u0[3:0]] == 8'hC3, "R6 fresh data", mlog[u0[3:0]], 8'hC3);

    // R9 continuous receive
    slv_pat = 8'h5C;
    idle(5);
    u0 = n_units; i0 = n_irq;
    wr_cfg(cfgv(1, 0, 1, 1, 0, 0));
    wait_units(u0, 3, 400);
    chk(n_units - u0 >= 3, "R9 repeats", n_units - u0, 3);
    chk(mlog[4'(n_units - 1)] == 8'hFF, "R9 filler ones", mlog[4'(n_units - 1)], 8'hFF);
    chk(!rx_empty && rx_rdata == 8'h5C, "R9 captured", rx_rdata, 8'h5C);
    wr_cfg(cfgv(1, 0, 1, 1, 1, 0));
    r0 = n_units;
    wait_units(r0, 3, 400);
    chk(n_units - r0 >= 3, "R9 runs across clear", n_units - r0, 3);
    wr_cfg(cfgv(1, 0, 0, 1, 0, 0));
    idle(40);
    chk(cs_n && (n_rises % 8 == 0), "R9 stopped whole unit", n_rises % 8, 0);
    r0 = n_units;
    idle(100);
    chk(n_units == r0, "R9 stays stopped", n_units - r0, 0);
    chk(n_irq - i0 == n_units - u0, "R8 pulse per unit", n_irq - i0, n_units - u0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule